// File: doc/BRIEF.md
# Lockstep Multi-Lane ANS Symbol Decoder

This block runs several independent asymmetric-numeral-system decoding lanes side by side. All lanes share a single stream of 16-bit words. Each lane holds a 32-bit state and uses a fixed two-symbol model. Symbol 0 has probability 1/4 and symbol 1 has probability 3/4. The lower bound of the normalised range is 65536.

On every step pulse, every lane decodes one symbol. Any lane whose reduced state has dropped below the bound then pulls exactly one word from the stream. The lanes that need a word are served in ascending lane order. Lane i reads the word that sits after all the words taken by the needy lanes below it. The shared read pointer then moves past every word taken in that step.

This ordering makes the stream identical to what a set of scalar decoders, run one after another in lane order on a single buffer, would consume. The ordering holds for any lane count. Before decoding starts, the initial lane states are written one at a time through a load port.

The word store sits outside the block. The block presents one read address per lane slot, starting at the pointer, and receives the words at those addresses in the same cycle.

Top module: `ilv_ans_decoder`

## Requirements
- R1: While reset is asserted, and right after it is released, every lane state is 0, `rd_ptr` is 0 and `sym_valid` is 0.
- R2: A cycle with `load_valid` high and `step` low writes `load_state` into lane `load_lane` at the next edge. The other lanes and `rd_ptr` are left unchanged.
- R3: A step decodes each lane from its state x. When x mod 4 is 0, the symbol is 0 and the reduced state is x/4. Otherwise, the symbol is 1 and the reduced state is 3*floor(x/4) + (x mod 4) - 1. Bit i of `sym_out` carries lane i's symbol. `sym_valid` is high for exactly the one cycle after the step edge.
- R4: A lane whose reduced state is below 65536 gets the new state reduced*65536 + word. Any other lane keeps its reduced state.
- R5: A lane that needs a word reads the word at `rd_ptr` + (number of needy lanes with a lower index).
- R6: After a step, `rd_ptr` has grown by the number of lanes that took a word. This is 0 when no lane needed one and equals the lane count when all lanes did.
- R7: Address slot k is `mem_addr[k*AW +: AW]` and always equals `rd_ptr` + k. Its word arrives on `mem_data[k*16 +: 16]`.
- R8: In a cycle with neither `step` nor `load_valid`, no state and no pointer changes, and `sym_valid` is 0 in the following cycle.
- R9: When `step` and `load_valid` are both high, the step is performed and the load is ignored.
- R10: Over a long run, the lane states, symbols and pointer match N scalar decoders processed in lane order on one shared buffer.
- R11: `rd_ptr` wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_valid | input | 1 | Write an initial state into one lane |
| load_lane | input | LW | Lane index for the load |
| load_state | input | 32 | State value to load |
| step | input | 1 | Decode one symbol in every lane |
| mem_addr | output | LANES*AW | Word read address per slot, rd_ptr + k |
| mem_data | input | LANES*16 | Word read back for each address slot |
| sym_out | output | LANES | Decoded symbol per lane |
| sym_valid | output | 1 | sym_out is new this cycle |
| rd_ptr | output | AW | Shared stream read pointer |
| state_flat | output | LANES*32 | Current state of every lane |

## Verification
Step, load, state and pointer results are all registered. Each is therefore due exactly one edge after the cycle that carries the request. The bench drives requests at the falling edge and compares against its serial reference model at the next falling edge.

The memory reply is combinational from the address outputs. Address slots can therefore be checked in the same half cycle as the pointer. `sym_valid` is checked high one half cycle after the step edge and low one full cycle later.

// File: rtl/ilv_ans_decoder.sv
module ilv_ans_decoder #(
  parameter int LANES = 4,
  parameter int AW    = 8,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_valid,
  input  logic [LW-1:0]         load_lane,
  input  logic [31:0]           load_state,
  input  logic                  step,
  output logic [LANES*AW-1:0]   mem_addr,
  input  logic [LANES*16-1:0]   mem_data,
  output logic [LANES-1:0]      sym_out,
  output logic                  sym_valid,
  output logic [AW-1:0]         rd_ptr,
  output logic [LANES*32-1:0]   state_flat
);

  localparam logic [31:0] LBOUND = 32'h0001_0000;

  logic [31:0]      x   [LANES];
  logic [31:0]      dec [LANES];
  logic [31:0]      nx  [LANES];
  logic [LANES-1:0] sym_n;
  logic [LANES-1:0] need;
  logic [LANES-1:0] in_rng;
  logic [AW-1:0]    adv;
  int               cnt;

  always_comb begin
    cnt = 0;
    for (int i = 0; i < LANES; i++) begin
      sym_n[i] = (x[i][1:0] != 2'd0);
      dec[i]   = sym_n[i] ? ((x[i] >> 2) * 32'd3 + {30'd0, x[i][1:0]} - 32'd1)
                          : (x[i] >> 2);
      need[i]  = dec[i] < LBOUND;
      nx[i]    = need[i] ? {dec[i][15:0], mem_data[cnt*16 +: 16]} : dec[i];
      cnt      = cnt + int'(need[i]);
    end
    adv = AW'(cnt);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    assign mem_addr[k*AW +: AW]   = rd_ptr + AW'(k);
    assign state_flat[k*32 +: 32] = x[k];
    assign in_rng[k]              = x[k] >= LBOUND;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) x[i] <= '0;
      rd_ptr    <= '0;
      sym_out   <= '0;
      sym_valid <= 1'b0;
    end else begin
      sym_valid <= step;
      if (step) begin
        for (int i = 0; i < LANES; i++) x[i] <= nx[i];
        sym_out <= sym_n;
        rd_ptr  <= rd_ptr + adv;
      end else if (load_valid && (int'(load_lane) < LANES)) begin
        x[load_lane] <= load_state;
      end
    end
  end

  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> sym_valid); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_valid) |=> ($stable(state_flat) && $stable(rd_ptr) && !sym_valid)); // R8
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ((rd_ptr - $past(rd_ptr)) <= AW'(LANES))); // R6
  AST_PTR_STILL_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && load_valid) |=> $stable(rd_ptr)); // R2
  AST_STAY_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (&in_rng)) |=> (&in_rng)); // R4

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    AST_SYM_ZERO_DIV4: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && !sym_out[i]) |-> ($past(state_flat[i*32 +: 2]) == 2'd0)); // R3
    AST_SYM_ONE_NDIV4: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_valid && sym_out[i]) |-> ($past(state_flat[i*32 +: 2]) != 2'd0)); // R3
    AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (load_valid && !step && (int'(load_lane) == i)) |=>
        (state_flat[i*32 +: 32] == $past(load_state))); // R2
  end

endmodule

// File: tb/ilv_ans_decoder_bench.sv
module ilv_ans_decoder_bench;
  localparam int LANES = 4;
  localparam int AW    = 8;
  localparam int LW    = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                load_valid = 1'b0;
  logic [LW-1:0]       load_lane = '0;
  logic [31:0]         load_state = '0;
  logic                step = 1'b0;
  logic [LANES*AW-1:0] mem_addr;
  logic [LANES*16-1:0] mem_data;
  logic [LANES-1:0]    sym_out;
  logic                sym_valid;
  logic [AW-1:0]       rd_ptr;
  logic [LANES*32-1:0] state_flat;

  ilv_ans_decoder #(.LANES(LANES), .AW(AW)) u_ilv_ans_decoder (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_lane(load_lane),
    .load_state(load_state), .step(step), .mem_addr(mem_addr), .mem_data(mem_data),
    .sym_out(sym_out), .sym_valid(sym_valid), .rd_ptr(rd_ptr), .state_flat(state_flat)
  );

  always #4 clk = ~clk;

  logic [15:0] mem [256];
  always_comb begin
    for (int k = 0; k < LANES; k++) mem_data[k*16 +: 16] = mem[mem_addr[k*AW +: AW]];
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [31:0]      ref_x [LANES];
  logic [AW-1:0]    ref_ptr = '0;
  logic [LANES-1:0] ref_sym = '0;
  int               ref_total = 0;
  logic [31:0]      lfsr = 32'h1234_5678;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_step();
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] q;
      logic [31:0] d;
      q = ref_x[i] >> 2;
      if (ref_x[i][1:0] == 2'd0) begin
        ref_sym[i] = 1'b0; d = q;
      end else begin
        ref_sym[i] = 1'b1; d = 3 * q + {30'd0, ref_x[i][1:0]} - 1;
      end
      if (d < 32'h10000) begin
        d = {d[15:0], mem[ref_ptr]};
        ref_ptr = ref_ptr + 1'b1;
        ref_total++;
      end
      ref_x[i] = d;
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < LANES; i++) check(tag, 64'(state_flat[i*32 +: 32]), 64'(ref_x[i]));
    check(tag, 64'(rd_ptr), 64'(ref_ptr));
  endtask

  task automatic load_one(input int lane, input logic [31:0] v);
    @(negedge clk);
    load_valid = 1'b1; load_lane = LW'(lane); load_state = v;
    @(negedge clk);
    load_valid = 1'b0;
    ref_x[lane] = v;
  endtask

  task automatic do_step(input string tag);
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    ref_step();
    check({tag, " R3 valid"}, 64'(sym_valid), 64'd1);
    check({tag, " R3 sym"}, 64'(sym_out), 64'(ref_sym));
    check_all(tag);
  endtask

  task automatic t_reset();
    check("R1 ptr", 64'(rd_ptr), 64'd0);
    check("R1 valid", 64'(sym_valid), 64'd0);
    check("R1 states", 64'(|state_flat), 64'd0);
    for (int i = 0; i < LANES; i++) ref_x[i] = '0;
  endtask

  task automatic t_load();
    load_one(0, 32'h0004_0000);
    load_one(1, 32'h0001_0001);
    load_one(2, 32'h0001_0000);
    load_one(3, 32'hFFFF_FFFF);
    check_all("R2 load");
  endtask

  task automatic t_idle();
    @(negedge clk);
    load_lane = 2'd1; load_state = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check("R8 valid", 64'(sym_valid), 64'd0);
    check_all("R8 idle");
  endtask

  task automatic t_mixed();
    do_step("R4 R5 R6 mixed");
    check("R4 lane1 word", 64'(state_flat[32 +: 32]), 64'({16'hC000, mem[0]}));
    check("R5 lane2 word", 64'(state_flat[64 +: 32]), 64'({16'h4000, mem[1]}));
    check("R6 ptr two", 64'(rd_ptr), 64'd2);
    @(negedge clk);
    check("R3 valid falls", 64'(sym_valid), 64'd0);
  endtask

  task automatic t_addr();
    for (int k = 0; k < LANES; k++)
      check("R7 addr", 64'(mem_addr[k*AW +: AW]), 64'(rd_ptr + AW'(k)));
  endtask

  task automatic t_all_none();
    for (int i = 0; i < LANES; i++) load_one(i, 32'h0001_0000);
    do_step("R6 all");
    check("R6 ptr +lanes", 64'(rd_ptr), 64'(ref_ptr));
    for (int i = 0; i < LANES; i++) load_one(i, 32'hFFFF_FFF0 + 32'(i));
    do_step("R6 none");
  endtask

  task automatic t_priority();
    @(negedge clk);
    step = 1'b1; load_valid = 1'b1; load_lane = 2'd2; load_state = 32'h0123_4567;
    @(negedge clk);
    step = 1'b0; load_valid = 1'b0;
    ref_step();
    check("R9 load ignored", 64'(state_flat[64 +: 32]), 64'(ref_x[2]));
    check_all("R9 step wins");
  endtask

  task automatic t_random();
    for (int i = 0; i < LANES; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      load_one(i, lfsr | 32'h0001_0000);
    end
    for (int n = 0; n < 300; n++) do_step("R10 serial match");
  endtask

  task automatic t_wrap();
    for (int n = 0; n < 70; n++) begin
      for (int i = 0; i < LANES; i++) load_one(i, 32'h0001_0000);
      do_step("R11 run");
    end
    check("R11 wrap", 64'(rd_ptr), 64'(ref_total % 256));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503 + 7) ^ (i >> 3));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_idle();
    t_mixed();
    t_addr();
    t_all_none();
    t_addr();
    t_priority();
    t_random();
    t_wrap();
    t_addr();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule